// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that completes one instruction on every clock cycle. It holds a program counter, thirty-two 32-bit general registers, an instruction store and a data store. In each cycle it fetches the word the program counter selects and decodes its 6-bit opcode into a set of control signals. It reads two registers, computes a result, and then updates a register, a data word or the program counter. A register is written on the falling edge of the clock, in the middle of the instruction's own cycle. The program counter and the data store change on the rising edge.

The two stores are filled through a word-load stream port, and only while the core is held in reset. A load word is accepted on a rising edge when `ld_valid` and `ld_ready` are both high. `ld_ready` is high exactly while `rst` is high, so a load presented while the core runs is held off and never takes effect. A sender that sees `ld_ready` low must keep the word presented, or withdraw it; it is not consumed. Plain outputs show the program counter, the current instruction and the write that the current instruction makes. Two combinational peek ports let the surrounding logic read any register and any data word.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. `ld_ready` equals `rst`. A load word is written on a rising edge with `ld_valid` and `ld_ready` high: to the data store when `ld_to_dmem` is 1, otherwise to the instruction store, at word index `ld_addr`. While the core runs, a load is ignored.
- R2: The fields of an instruction are: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0], and immediate [15:0], which is sign-extended. The instruction is fetched from word `pc[9:2]` (default depth). Every instruction other than jump and branch advances the program counter by 4.
- R3: Opcode 000000 selects an ALU operation on rs (a) and rt (b). The result is written to rd. The function codes are: 100000 a+b, 100010 a-b, 011000 the low 32 bits of unsigned a*b, 011011 unsigned a/b (all ones when b is 0), 001101 a AND b, 001111 a OR b, 000011 b shifted right logically by the shift amount, 000010 b shifted left by the shift amount, 001011 NOT b. Any other function code writes nothing.
- R4: Opcode 100011 (load) reads the data word at rs plus the immediate and writes it to rt.
- R5: Opcode 101011 (store) writes rt to the data word at rs plus the immediate. It writes no register.
- R6: Opcodes 001100 and 001111 both write rs plus the immediate to rt.
- R7: Opcode 011101 branches when rs equals rt. The new program counter is pc+4 plus the immediate shifted left by 2. When rs differs from rt, the program counter advances by 4.
- R8: Opcode 000010 jumps. The new program counter is formed from bits [31:28] of pc+4, then instruction bits [25:0], then two zero bits.
- R9: Register 0 always reads as 0, and a write to it is dropped.
- R10: The all-zero word and every opcode not listed above change nothing except the program counter.
- R11: A register write lands on the falling edge inside the instruction's own cycle. `rf_we_o`, `rf_waddr_o` and `rf_wdata_o` show that write.
- R12: A data store write lands on the rising edge that ends the instruction. `dm_we_o`, `dm_addr_o` and `dm_wdata_o` show that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| ld_valid | input | 1 | A load word is presented |
| ld_ready | output | 1 | The load port accepts a word (high during reset) |
| ld_to_dmem | input | 1 | 1 selects the data store, 0 the instruction store |
| ld_addr | input | 8 | Word index of the load |
| ld_data | input | 32 | Load word |
| pc_o | output | 32 | Program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | The current instruction writes a register |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | The current instruction writes the data store |
| dm_addr_o | output | 32 | Byte address of the data write |
| dm_wdata_o | output | 32 | Data word being written |
| peek_reg | input | 5 | Register to observe |
| peek_reg_data | output | 32 | Value of that register |
| peek_word | input | 8 | Data store word to observe |
| peek_word_data | output | 32 | Value of that word |

## Verification
The alignment property assumes that every load and store address is a multiple of four. The random programs make sure of this by using register 0 as the base of every memory access and a multiple of four as the offset. The properties on the program counter assume that `rst` is high from time zero, so that the first cycles they see begin from a known counter. Register contents are not defined after reset, so every program first writes each register it reads. The random program does this with a prologue that sets all 31 writable registers.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_ALU  = 6'b000000;
  localparam logic [5:0] OPC_JMP  = 6'b000010;
  localparam logic [5:0] OPC_IMMB = 6'b001111;
  localparam logic [5:0] OPC_IMMA = 6'b001100;
  localparam logic [5:0] OPC_BEQ  = 6'b011101;
  localparam logic [5:0] OPC_LD   = 6'b100011;
  localparam logic [5:0] OPC_ST   = 6'b101011;

  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_MUL  = 6'b011000;
  localparam logic [5:0] FN_DIV  = 6'b011011;
  localparam logic [5:0] FN_AND  = 6'b001101;
  localparam logic [5:0] FN_OR   = 6'b001111;
  localparam logic [5:0] FN_SRL  = 6'b000011;
  localparam logic [5:0] FN_SLL  = 6'b000010;
  localparam logic [5:0] FN_NOT  = 6'b001011;

  typedef struct packed {
    logic dst_rd;     // destination from rd instead of rt
    logic src_imm;    // second ALU operand is the immediate
    logic from_mem;   // write-back value comes from the data store
    logic reg_we;
    logic mem_rd;
    logic mem_we;
    logic is_branch;
    logic is_jump;
    logic use_funct;  // ALU obeys the function field, else adds
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);
  always_comb begin
    ctl = '0;
    case (opcode)
      OPC_ALU: begin
        ctl.dst_rd    = 1'b1;
        ctl.reg_we    = 1'b1;
        ctl.use_funct = 1'b1;
      end
      OPC_JMP: ctl.is_jump = 1'b1;
      OPC_IMMA, OPC_IMMB: begin
        ctl.src_imm = 1'b1;
        ctl.reg_we  = 1'b1;
      end
      OPC_BEQ: ctl.is_branch = 1'b1;
      OPC_LD: begin
        ctl.src_imm  = 1'b1;
        ctl.from_mem = 1'b1;
        ctl.mem_rd   = 1'b1;
        ctl.reg_we   = 1'b1;
      end
      OPC_ST: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         use_funct,
  input  logic [5:0]   funct,
  input  logic [4:0]   shamt,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         ok
);
  logic [2*W-1:0] prod;
  assign prod = a * b;

  always_comb begin
    ok = 1'b1;
    y  = a + b;
    if (use_funct) begin
      case (funct)
        FN_ADD: y = a + b;
        FN_SUB: y = a - b;
        FN_MUL: y = prod[W-1:0];
        FN_DIV: y = (b == '0) ? '1 : a / b;
        FN_AND: y = a & b;
        FN_OR:  y = a | b;
        FN_SRL: y = b >> shamt;
        FN_SLL: y = b << shamt;
        FN_NOT: y = ~b;
        default: begin
          y  = '0;
          ok = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  parameter int NRD   = 3,
  localparam int RAW  = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [RAW-1:0]          waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][RAW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] regs [NREGS];

  // writes land mid-cycle so the next instruction sees them
  always_ff @(negedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
  end
endmodule

// File: rtl/sc_pcgen.sv
module sc_pcgen #(
  parameter int W = 32
) (
  input  logic [W-1:0] pc,
  input  logic [15:0]  imm,
  input  logic [25:0]  target,
  input  logic         is_branch,
  input  logic         is_jump,
  input  logic         equal,
  output logic [W-1:0] next_pc
);
  logic [W-1:0] seq_pc, br_pc, jmp_pc;

  assign seq_pc = pc + W'(4);
  assign br_pc  = seq_pc + {{(W-18){imm[15]}}, imm, 2'b00};
  assign jmp_pc = {seq_pc[W-1:28], target, 2'b00};

  always_comb begin
    if (is_jump)                 next_pc = jmp_pc;
    else if (is_branch && equal) next_pc = br_pc;
    else                         next_pc = seq_pc;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  parameter int NREGS      = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW,
  localparam int RAW = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic            ld_to_dmem,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] instr_o,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o,
  input  logic [RAW-1:0]  peek_reg,
  output logic [XLEN-1:0] peek_reg_data,
  input  logic [DAW-1:0]  peek_word,
  output logic [XLEN-1:0] peek_word_data
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [XLEN-1:0] pc_q, next_pc, instr;
  ctrl_t           ctl;
  logic            ld_fire;

  // field slices
  logic [5:0]     f_op, f_fn;
  logic [RAW-1:0] f_rs, f_rt, f_rd;
  logic [4:0]     f_sh;
  logic [15:0]    f_imm;
  logic [XLEN-1:0] imm_x;

  logic [2:0][RAW-1:0]  rf_ra;
  logic [2:0][XLEN-1:0] rf_rd;
  logic [XLEN-1:0] a_val, b_val, alu_b, alu_y, mem_q, wb_val;
  logic            alu_ok, reg_we;
  logic [RAW-1:0]  dst;
  logic [DAW-1:0]  dm_idx;

  assign ld_ready = rst;
  assign ld_fire  = ld_valid && ld_ready;

  assign instr = imem[pc_q[IAW+1:2]];
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_sh  = instr[10:6];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign imm_x = {{(XLEN-16){f_imm[15]}}, f_imm};

  sc_ctrl u_ctrl (
    .opcode (f_op),
    .ctl    (ctl)
  );

  assign rf_ra = {peek_reg, f_rt, f_rs};
  assign a_val = rf_rd[0];
  assign b_val = rf_rd[1];
  assign peek_reg_data = rf_rd[2];

  assign alu_b = ctl.src_imm ? imm_x : b_val;

  sc_alu #(.W(XLEN)) u_alu (
    .use_funct (ctl.use_funct),
    .funct     (f_fn),
    .shamt     (f_sh),
    .a         (a_val),
    .b         (alu_b),
    .y         (alu_y),
    .ok        (alu_ok)
  );

  assign dm_idx = alu_y[DAW+1:2];
  assign mem_q  = ctl.mem_rd ? dmem[dm_idx] : '0;
  assign wb_val = ctl.from_mem ? mem_q : alu_y;
  assign dst    = ctl.dst_rd ? f_rd : f_rt;
  assign reg_we = !rst && ctl.reg_we && alu_ok && (dst != '0);

  sc_regfile #(.NREGS(NREGS), .W(XLEN), .NRD(3)) u_rf (
    .clk   (clk),
    .we    (reg_we),
    .waddr (dst),
    .wdata (wb_val),
    .raddr (rf_ra),
    .rdata (rf_rd)
  );

  sc_pcgen #(.W(XLEN)) u_pcgen (
    .pc        (pc_q),
    .imm       (f_imm),
    .target    (instr[25:0]),
    .is_branch (ctl.is_branch),
    .is_jump   (ctl.is_jump),
    .equal     (a_val == b_val),
    .next_pc   (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  always_ff @(posedge clk) begin
    if (ld_fire && !ld_to_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_fire && ld_to_dmem)        dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (!rst && ctl.mem_we)      dmem[dm_idx] <= b_val;
  end

  assign peek_word_data = dmem[peek_word];

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = reg_we;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_val;
  assign dm_we_o    = !rst && ctl.mem_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = b_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic        dm_we_o,
  input logic [31:0] dm_addr_o,
  input logic [4:0]  peek_reg,
  input logic [31:0] peek_reg_data
);
  logic [5:0]  op;
  logic [31:0] seq, jt, bt;
  logic        known;

  assign op    = instr_o[31:26];
  assign seq   = pc_o + 32'd4;
  assign jt    = {seq[31:28], instr_o[25:0], 2'b00};
  assign bt    = seq + {{14{instr_o[15]}}, instr_o[15:0], 2'b00};
  assign known = (op == 6'b000000) || (op == 6'b000010) || (op == 6'b001111) ||
                 (op == 6'b001100) || (op == 6'b011101) || (op == 6'b100011) ||
                 (op == 6'b101011);

  // R1
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc_o == 32'd0));

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (op != 6'b000010 && op != 6'b011101) |=> (pc_o == $past(seq)));

  // R8
  pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000010) |=> (pc_o == $past(jt)));

  // R7
  pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b011101) |=> (pc_o == $past(seq) || pc_o == $past(bt)));

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (peek_reg == 5'd0) |-> (peek_reg_data == 32'd0));

  // R10
  unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!rf_we_o && !dm_we_o));

  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b101011) |-> (dm_we_o && !rf_we_o));

  // R4
  load_dst_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b100011 && instr_o[20:16] != 5'd0) |-> (rf_we_o && rf_waddr_o == instr_o[20:16]));

  // R12
  store_align_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> (dm_addr_o[1:0] == 2'b00));
endmodule

bind sc_core sc_core_chk u_chk (.*);

// File: tb/sc_core_tb.sv
`timescale 1ns/100ps
module sc_core_tb;
  localparam int IW  = 256;
  localparam int DW  = 256;
  localparam int IAW = $clog2(IW);
  localparam int DAW = $clog2(DW);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_to_dmem = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;
  logic [4:0]  peek_reg = '0;
  logic [31:0] peek_reg_data, peek_word_data;
  logic [7:0]  peek_word = '0;

  always #2.5 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_pc;
  logic [31:0] m_rf [32];
  logic [31:0] m_dm [DW];
  logic [31:0] m_im [IW];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] mk_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic void alu_ref(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b,
                                  input logic [4:0] sh, output logic [31:0] y, output bit ok);
    ok = 1;
    case (fn)
      6'b100000: y = a + b;
      6'b100010: y = a - b;
      6'b011000: y = a * b;
      6'b011011: y = (b == 0) ? 32'hFFFF_FFFF : a / b;
      6'b001101: y = a & b;
      6'b001111: y = a | b;
      6'b000011: y = b >> sh;
      6'b000010: y = b << sh;
      6'b001011: y = ~b;
      default: begin y = 0; ok = 0; end
    endcase
  endfunction

  // compare the current instruction against the model, then advance the model
  task automatic step_check();
    logic [31:0] ins, a, b, imm, pcp4, nxt, wd, ma;
    logic [5:0] op;
    logic [4:0] rs, rt, rd, wa;
    bit we, mwe, ok;
    string tg;
    ins = m_im[m_pc[IAW+1:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = m_rf[rs]; b = m_rf[rt];
    imm = {{16{ins[15]}}, ins[15:0]};
    pcp4 = m_pc + 4; nxt = pcp4;
    we = 0; mwe = 0; wa = 0; wd = 0; ma = 0; tg = "R10";
    chk(pc_o, m_pc, "R2", "program counter");
    chk(instr_o, ins, "R2", "fetched word");
    case (op)
      6'b000000: begin
        alu_ref(ins[5:0], a, b, ins[10:6], wd, ok);
        we = ok && rd != 0; wa = rd;
        tg = (ins == 0) ? "R10" : (ok && rd == 0) ? "R9" : "R3";
      end
      6'b000010: begin tg = "R8"; nxt = {pcp4[31:28], ins[25:0], 2'b00}; end
      6'b001100, 6'b001111: begin tg = (rt == 0) ? "R9" : "R6"; we = rt != 0; wa = rt; wd = a + imm; end
      6'b011101: begin tg = "R7"; if (a == b) nxt = pcp4 + (imm << 2); end
      6'b100011: begin tg = "R4"; ma = a + imm; wd = m_dm[ma[DAW+1:2]]; we = rt != 0; wa = rt; end
      6'b101011: begin tg = "R5"; mwe = 1; ma = a + imm; wd = b; end
      default: tg = "R10";
    endcase
    chk({31'd0, rf_we_o}, {31'd0, we}, tg, "register write enable");
    if (we) begin
      chk({27'd0, rf_waddr_o}, {27'd0, wa}, tg, "register write index");
      chk(rf_wdata_o, wd, tg, "register write value");
    end
    chk({31'd0, dm_we_o}, {31'd0, mwe}, tg, "store enable");
    if (mwe) begin
      chk(dm_addr_o, ma, tg, "store address");
      chk(dm_wdata_o, wd, tg, "store data");
    end
    if (we) m_rf[wa] = wd;
    if (mwe) m_dm[ma[DAW+1:2]] = wd;
    m_pc = nxt;
  endtask

  task automatic load_word(input bit to_dm, input int idx, input logic [31:0] d);
    ld_valid = 1; ld_to_dmem = to_dm; ld_addr = 8'(idx); ld_data = d;
    @(posedge clk); #0.5;
    ld_valid = 0;
  endtask

  task automatic enter_reset();
    @(posedge clk); #0.5 rst = 1;
    @(posedge clk); #0.5;
    m_pc = 0;
    // R1: ready is raised by reset and the counter returns to zero
    chk({31'd0, ld_ready}, 32'd1, "R1", "load ready in reset");
    chk(pc_o, 32'd0, "R1", "counter after reset");
  endtask

  task automatic leave_reset();
    @(posedge clk); #0.5 rst = 0; #0.5;
    chk({31'd0, ld_ready}, 32'd0, "R1", "load ready while running");
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      step_check();
      @(posedge clk); #1;
    end
  endtask

  function automatic logic [31:0] rand_instr();
    int k;
    logic [5:0] fns [9];
    fns = '{6'b100000, 6'b100010, 6'b011000, 6'b011011, 6'b001101,
            6'b001111, 6'b000011, 6'b000010, 6'b001011};
    k = $urandom % 10;
    case (k)
      0, 1, 2: begin
        if ($urandom % 8 == 0)
          return mk_r($urandom % 32, $urandom % 32, $urandom % 32, $urandom % 32, 6'($urandom));
        return mk_r($urandom % 32, $urandom % 32, $urandom % 32, $urandom % 32, fns[$urandom % 9]);
      end
      3: return mk_i(6'b001111, $urandom % 32, $urandom % 32, 16'($urandom));
      4: return mk_i(6'b001100, $urandom % 32, $urandom % 32, 16'($urandom));
      5: return mk_i(6'b100011, 0, $urandom % 32, 16'(4 * ($urandom % DW)));
      6: return mk_i(6'b101011, 0, $urandom % 32, 16'(4 * ($urandom % DW)));
      7: begin
        int r1;
        r1 = $urandom % 32;
        return mk_i(6'b011101, r1, ($urandom % 2) ? r1 : int'($urandom % 32), 16'($signed(int'($urandom % 17) - 8)));
      end
      8: return {6'b000010, 26'($urandom % IW)};
      default: return ($urandom % 2) ? 32'd0 : {6'b110001 + 6'($urandom % 4), 26'($urandom)};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4099));
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
    for (int i = 0; i < DW; i++) m_dm[i] = 0;
    for (int i = 0; i < IW; i++) m_im[i] = 0;

    // ---------------- directed program ----------------
    m_im[0]  = mk_i(6'b001111, 0, 1, 16'd5);
    m_im[1]  = mk_i(6'b001111, 0, 2, 16'hFFFD);
    m_im[2]  = mk_i(6'b001111, 0, 6, 16'd11);
    m_im[3]  = mk_i(6'b001100, 0, 9, 16'd44);
    m_im[4]  = mk_r(1, 2, 3, 0, 6'b100000);
    m_im[5]  = mk_r(1, 2, 4, 0, 6'b100010);
    m_im[6]  = mk_i(6'b001111, 1, 0, 16'd7);
    m_im[7]  = mk_i(6'b101011, 0, 3, 16'd8);
    m_im[8]  = mk_i(6'b100011, 0, 5, 16'd8);
    m_im[9]  = mk_i(6'b011101, 1, 1, 16'd1);
    m_im[10] = mk_i(6'b001111, 0, 6, 16'd99);
    m_im[11] = mk_i(6'b011101, 1, 2, 16'd5);
    m_im[12] = {6'b000010, 26'd14};
    m_im[13] = mk_i(6'b001111, 0, 6, 16'd77);
    m_im[14] = mk_r(1, 0, 7, 0, 6'b011011);
    m_im[15] = mk_r(0, 1, 8, 4, 6'b000010);
    m_im[16] = mk_r(1, 1, 9, 0, 6'b111111);
    m_im[17] = 32'hFC00_0000;
    enter_reset();
    for (int i = 0; i < 32; i++) load_word(0, i, m_im[i]);
    leave_reset();
    peek_reg = 5'd1;
    step_check();
    #2;
    // R11: the write of the first instruction is visible after the falling edge
    chk(peek_reg_data, 32'd5, "R11", "register after falling edge");
    @(posedge clk); #1;
    run(24);
    peek_reg = 5'd3; #0.1; chk(peek_reg_data, 32'd2, "R3", "add result");
    peek_reg = 5'd4; #0.1; chk(peek_reg_data, 32'd8, "R3", "sub result");
    peek_reg = 5'd5; #0.1; chk(peek_reg_data, 32'd2, "R4", "loaded word");
    peek_reg = 5'd6; #0.1; chk(peek_reg_data, 32'd11, "R7", "skipped by branch and jump");
    peek_reg = 5'd7; #0.1; chk(peek_reg_data, 32'hFFFF_FFFF, "R3", "divide by zero");
    peek_reg = 5'd8; #0.1; chk(peek_reg_data, 32'd80, "R3", "shift left");
    peek_reg = 5'd9; #0.1; chk(peek_reg_data, 32'd44, "R3", "unknown function ignored");
    peek_reg = 5'd0; #0.1; chk(peek_reg_data, 32'd0, "R9", "register zero");
    peek_word = 8'd2; #0.1; chk(peek_word_data, 32'd2, "R5", "stored word");

    // ---------------- random program ----------------
    for (int i = 1; i < 32; i++) m_im[i - 1] = mk_i(6'b001111, 0, i, 16'($urandom));
    for (int i = 31; i < IW; i++) m_im[i] = rand_instr();
    for (int i = 0; i < DW; i++) m_dm[i] = $urandom;
    enter_reset();
    for (int i = 0; i < IW; i++) load_word(0, i, m_im[i]);
    for (int i = 0; i < DW; i++) load_word(1, i, m_dm[i]);
    leave_reset();
    // R1: a load presented while running must be ignored
    ld_valid = 1; ld_to_dmem = 1; ld_addr = 8'd5; ld_data = 32'hDEAD_BEEF;
    run(3000);
    ld_valid = 0;
    for (int i = 0; i < 32; i++) begin
      peek_reg = 5'(i); #0.1;
      chk(peek_reg_data, m_rf[i], (i == 0) ? "R9" : "R11", "final register");
    end
    for (int i = 0; i < DW; i++) begin
      peek_word = 8'(i); #0.1;
      chk(peek_word_data, m_dm[i], (i == 5) ? "R1" : "R12", "final data word");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule